// File: doc/BRIEF.md
# Serial Receive Interrupt and Overrun Controller

This block holds the receive-side interrupt and status logic for a byte-wide serial port. The port can act as an I2C master or an I2C slave, and the rules here are the same in both roles. Received bytes go into a two-entry buffer. Software drains that buffer through a read strobe, and the oldest byte is always shown on the read data output.

A completion strobe from the bus engine sets a completion flag and captures a 3-bit code that says which bus event finished. A transmit or receive trigger that arrives while two unread bytes are held counts as an overrun and sets an error flag. Each flag has its own enable bit. A flag whose enable is set drives the single interrupt request to an external interrupt controller. Software clears a flag by writing a 1 to its bit.

To recover from an overrun, software clears the error flag and then pops the buffer twice.

Top module: `rxirq_ctrl`

## Requirements
- R1: After reset, both enables, both flags, the status code, the buffer count and `irq` are 0.
- R2: The buffer holds up to two bytes in arrival order. `rd_data` shows the oldest byte. `rd_pop` removes it on the next clock edge. `rx_count` (2 bits) gives the number of bytes held.
- R3: While the buffer is empty, `rd_data` is 0, and a pop leaves `rx_count` at 0.
- R4: A byte presented while `rx_count` is 2 at the clock edge is discarded. The two held bytes are kept in order, even if a pop happens in the same cycle.
- R5: `done_stb` sets `cmp_flag` and loads `done_code` into `status_code` on the next edge. The code meanings are: 0 start, 1 stop, 2 end of transmit, 3 end of receive, 4 ACK/NAK sent, 5 ACK received, 6 NAK received, 7 reserved. Without a strobe, the code holds its value.
- R6: `trig` with `rx_count` equal to 2 sets `err_flag` on the next edge. `trig` with a lower count does not set it.
- R7: When `clr_we` is high, a 1 on `clr_cmp` or `clr_err` clears that flag on the next edge. A 0 on either bit leaves that flag unchanged.
- R8: If a hardware set and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R9: `irq` equals (cmp_flag AND completion enable) OR (err_flag AND error enable). It rises in the same cycle as the flag that causes it. The enables are loaded through `en_we`. A flag still sets while its enable is 0.
- R10: After the error flag is cleared and the buffer is popped twice, `rx_count` is 0, and a following `trig` does not set `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | DW | Received byte |
| rd_pop | input | 1 | Software read of the buffer (pops the oldest byte) |
| rd_data | output | DW | Oldest held byte, 0 when empty |
| rx_count | output | 2 | Number of bytes held |
| trig | input | 1 | Transmit or receive trigger |
| done_stb | input | 1 | Operation-complete strobe |
| done_code | input | 3 | Event code carried with `done_stb` |
| status_code | output | 3 | Latched event code |
| en_we | input | 1 | Enable register write strobe |
| en_cmp_in | input | 1 | Completion enable value to write |
| en_err_in | input | 1 | Error enable value to write |
| clr_we | input | 1 | Flag clear write strobe |
| clr_cmp | input | 1 | Write 1 to clear the completion flag |
| clr_err | input | 1 | Write 1 to clear the error flag |
| cmp_flag | output | 1 | Completion flag |
| err_flag | output | 1 | Receive overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
An occupancy count that is off by one shows up in the first cycle after the fault. It either reports a missed overrun or a false overrun on the next trigger, or it makes `rd_data` show a stale or zero byte. A wrong read pointer swaps the order of two held bytes, and that is seen on the pop that follows. Flag or enable state that is wrong appears on `irq`, `cmp_flag` or `err_flag` in the cycle right after the bad edge. Because of this, the bench compares every output against its model on every clock.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        EV_START    = 3'd0,
        EV_STOP     = 3'd1,
        EV_TX_END   = 3'd2,
        EV_RX_END   = 3'd3,
        EV_ACK_SENT = 3'd4,
        EV_ACK_RCV  = 3'd5,
        EV_NAK_RCV  = 3'd6,
        EV_RSVD     = 3'd7
    } ev_code_e;

    typedef struct packed {
        logic              cmp_en;
        logic              err_en;
        logic [CODE_W-1:0] code;
    } ctl_state_t;
endpackage

// File: rtl/rxirq_fifo.sv
module rxirq_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 2,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            rd_ptr;
        logic [CW-1:0]            cnt;
    } fifo_t;

    fifo_t st_d, st_q;

    logic do_pop, do_push;
    logic [PW-1:0] wr_idx;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && (st_q.cnt != CW'(DEPTH));
        wr_idx  = PW'((32'(st_q.rd_ptr) + 32'(st_q.cnt)) % DEPTH);
        if (do_push) begin
            st_d.mem[wr_idx] = push_data;
        end
        if (do_pop) begin
            st_d.rd_ptr = PW'((32'(st_q.rd_ptr) + 1) % DEPTH);
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = (st_q.cnt == '0) ? '0 : st_q.mem[st_q.rd_ptr];
    assign count = st_q.cnt;
endmodule

// File: rtl/rxirq_flag.sv
module rxirq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (sw_clr) flag_d = 1'b0;
        if (hw_set) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/rxirq_ctrl.sv
module rxirq_ctrl
    import rxirq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DW-1:0]     rx_data,
    input  logic              rd_pop,
    output logic [DW-1:0]     rd_data,
    output logic [1:0]        rx_count,
    input  logic              trig,
    input  logic              done_stb,
    input  logic [CODE_W-1:0] done_code,
    output logic [CODE_W-1:0] status_code,
    input  logic              en_we,
    input  logic              en_cmp_in,
    input  logic              en_err_in,
    input  logic              clr_we,
    input  logic              clr_cmp,
    input  logic              clr_err,
    output logic              cmp_flag,
    output logic              err_flag,
    output logic              irq
);
    localparam int DEPTH = 2;

    ctl_state_t st_d, st_q;
    logic [1:0] occ;
    logic       overrun;

    rxirq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rx_valid),
        .push_data (rx_data),
        .pop       (rd_pop),
        .head      (rd_data),
        .count     (occ)
    );

    // Overrun is judged on the occupancy held at the trigger edge.
    assign overrun = trig && (occ == 2'(DEPTH));

    logic [1:0] hw_set, sw_clr, flags;
    assign hw_set = {overrun, done_stb};
    assign sw_clr = {clr_we && clr_err, clr_we && clr_cmp};

    for (genvar g = 0; g < 2; g++) begin : g_flag
        rxirq_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (hw_set[g]),
            .sw_clr (sw_clr[g]),
            .flag   (flags[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (en_we) begin
            st_d.cmp_en = en_cmp_in;
            st_d.err_en = en_err_in;
        end
        if (done_stb) begin
            st_d.code = done_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_flag    = flags[0];
    assign err_flag    = flags[1];
    assign status_code = st_q.code;
    assign rx_count    = occ;
    assign irq         = (flags[0] && st_q.cmp_en) || (flags[1] && st_q.err_en);
endmodule

// File: rtl/rxirq_chk.sv
module rxirq_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rd_pop,
    input logic [DW-1:0] rd_data,
    input logic [1:0]    rx_count,
    input logic          trig,
    input logic          done_stb,
    input logic [2:0]    done_code,
    input logic [2:0]    status_code,
    input logic          clr_we,
    input logic          clr_cmp,
    input logic          clr_err,
    input logic          cmp_flag,
    input logic          err_flag,
    input logic          irq
);
    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= 2'd2);

    p_empty_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == 2'd0) |-> (rd_data == '0));

    p_full_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == 2'd2 && rx_valid && !rd_pop) |=> (rx_count == 2'd2) && $stable(rd_data));

    p_code_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |=> (status_code == $past(done_code)));

    p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && rx_count == 2'd2) |=> err_flag);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_cmp && !done_stb) |=> !cmp_flag);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |=> cmp_flag);

    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cmp_flag || err_flag));
endmodule

bind rxirq_ctrl rxirq_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rd_pop      (rd_pop),
    .rd_data     (rd_data),
    .rx_count    (rx_count),
    .trig        (trig),
    .done_stb    (done_stb),
    .done_code   (done_code),
    .status_code (status_code),
    .clr_we      (clr_we),
    .clr_cmp     (clr_cmp),
    .clr_err     (clr_err),
    .cmp_flag    (cmp_flag),
    .err_flag    (err_flag),
    .irq         (irq)
);

// File: tb/rxirq_ctrl_test.sv
module rxirq_ctrl_test;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_valid = 0, rd_pop = 0, trig = 0, done_stb = 0;
    logic [DW-1:0] rx_data = '0;
    logic [2:0] done_code = '0;
    logic en_we = 0, en_cmp_in = 0, en_err_in = 0;
    logic clr_we = 0, clr_cmp = 0, clr_err = 0;
    logic [DW-1:0] rd_data;
    logic [1:0] rx_count;
    logic [2:0] status_code;
    logic cmp_flag, err_flag, irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rxirq_ctrl #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rd_pop(rd_pop), .rd_data(rd_data), .rx_count(rx_count), .trig(trig),
        .done_stb(done_stb), .done_code(done_code), .status_code(status_code),
        .en_we(en_we), .en_cmp_in(en_cmp_in), .en_err_in(en_err_in),
        .clr_we(clr_we), .clr_cmp(clr_cmp), .clr_err(clr_err),
        .cmp_flag(cmp_flag), .err_flag(err_flag), .irq(irq)
    );

    // Behavioural reference model
    logic [DW-1:0] q[$];
    bit m_cmp, m_err, m_cen, m_een;
    int m_code;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_cmp = 0; m_err = 0; m_cen = 0; m_een = 0; m_code = 0;
        end else begin
            int held;
            held = q.size();
            if (clr_we && clr_cmp) m_cmp = 0;
            if (clr_we && clr_err) m_err = 0;
            if (done_stb) begin m_cmp = 1; m_code = done_code; end
            if (trig && held == 2) m_err = 1;
            if (en_we) begin m_cen = en_cmp_in; m_een = en_err_in; end
            if (rd_pop && held > 0) void'(q.pop_front());
            if (rx_valid && held < 2) q.push_back(rx_data);
        end
    end

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d at cycle %0d", req, got, exp, cycles);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cycles++;
            chk("R2 count", rx_count, q.size());
            chk("R2 R3 rd_data", rd_data, (q.size() == 0) ? 0 : q[0]);
            chk("R5 cmp_flag", cmp_flag, m_cmp);
            chk("R5 status_code", status_code, m_code);
            chk("R6 err_flag", err_flag, m_err);
            chk("R9 irq", irq, (m_cmp && m_cen) || (m_err && m_een));
        end
    end

    task automatic idle();
        rx_valid = 0; rd_pop = 0; trig = 0; done_stb = 0;
        en_we = 0; clr_we = 0; clr_cmp = 0; clr_err = 0;
    endtask

    task automatic tick();
        @(negedge clk); #1;
        idle();
    endtask

    task automatic push(int b);
        rx_valid = 1; rx_data = DW'(b); tick();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // R1: reset values
        chk("R1 cmp_flag", cmp_flag, 0);
        chk("R1 err_flag", err_flag, 0);
        chk("R1 code", status_code, 0);
        chk("R1 count", rx_count, 0);
        chk("R1 irq", irq, 0);

        // R3: pop on empty
        rd_pop = 1; tick();
        chk("R3 empty pop count", rx_count, 0);
        chk("R3 empty data", rd_data, 0);

        // R2: order
        push(8'hA1); push(8'hB2);
        chk("R2 head", rd_data, 8'hA1);
        // R4: full discard with simultaneous pop
        rx_valid = 1; rx_data = 8'hCC; rd_pop = 1; tick();
        chk("R4 kept", rd_data, 8'hB2);
        chk("R4 count", rx_count, 1);
        push(8'hD3);
        rx_valid = 1; rx_data = 8'hEE; tick();
        chk("R4 discard count", rx_count, 2);
        chk("R4 discard head", rd_data, 8'hB2);

        // R9: flag without enable sets but no irq
        done_stb = 1; done_code = 3'd5; tick();
        chk("R9 flag no enable", cmp_flag, 1);
        chk("R9 no irq", irq, 0);
        chk("R5 code ack rcv", status_code, 5);
        en_we = 1; en_cmp_in = 1; en_err_in = 1; tick();
        chk("R9 irq enabled", irq, 1);

        // R7: write 0 no effect, write 1 clears
        clr_we = 1; tick();
        chk("R7 write0", cmp_flag, 1);
        clr_we = 1; clr_cmp = 1; tick();
        chk("R7 write1", cmp_flag, 0);
        chk("R7 irq low", irq, 0);

        // R8: set beats clear
        clr_we = 1; clr_cmp = 1; done_stb = 1; done_code = 3'd6; tick();
        chk("R8 set wins", cmp_flag, 1);
        chk("R5 code nak", status_code, 6);
        clr_we = 1; clr_cmp = 1; tick();

        // R6: overrun with two held
        trig = 1; tick();
        chk("R6 overrun", err_flag, 1);
        chk("R9 err irq", irq, 1);

        // R10: recovery
        clr_we = 1; clr_err = 1; tick();
        chk("R10 cleared", err_flag, 0);
        rd_pop = 1; tick();
        rd_pop = 1; tick();
        chk("R10 drained", rx_count, 0);
        trig = 1; tick();
        chk("R10 no overrun", err_flag, 0);

        // R6: trigger with one byte held
        push(8'h11);
        trig = 1; tick();
        chk("R6 one held", err_flag, 0);
        push(8'h22);
        // overrun set vs clear same cycle (R8)
        trig = 1; clr_we = 1; clr_err = 1; tick();
        chk("R8 err set wins", err_flag, 1);

        // sweep all codes (R5)
        for (int k = 0; k < 8; k++) begin
            done_stb = 1; done_code = 3'(k); tick();
            chk("R5 code sweep", status_code, k);
        end
        // mixed traffic
        for (int k = 0; k < 200; k++) begin
            rx_valid = (k % 3) != 0; rx_data = DW'(k * 7);
            rd_pop = (k % 4) == 1; trig = (k % 5) == 2;
            done_stb = (k % 7) == 3; done_code = 3'(k);
            clr_we = (k % 6) == 0; clr_cmp = k[1]; clr_err = k[2];
            en_we = (k % 50) == 25; en_cmp_in = k[3]; en_err_in = k[4];
            @(negedge clk); #1;
        end
        idle(); tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule